// File: doc/BRIEF.md
# Programmable-Priority Interrupt Controller

This block sits on a 16-bit bus beside a host processor that takes seven prioritised interrupt levels on a 3-bit encoded input. Five event sources feed it: a processor-to-processor doorbell, an external line, a raster-position compare, a serial port and the vertical blank. Each source has a 3-bit priority level that software programs. An event marks its source pending, and the host input shows the highest level among the pending sources until software acknowledges each one.

The address space is split into 8 KB windows. A source's level register and its acknowledge window have fixed positions, so the acknowledge window of a source lies 0x10000 above its level window. Register data travels only on the low byte lane. Software acknowledges a source by reading or writing its acknowledge window. An auxiliary control window can also clear the vertical-blank request. The vertical-blank event comes from a scan-line counter input and fires when that counter reaches the configured line, which is 480 by default.

Top module: `prio_irq_ctrl`

## Requirements
- R1: The level registers sit at byte offsets 0x06000 (doorbell), 0x08000 (external), 0x0A000 (position), 0x0C000 (serial) and 0x0E000 (vertical blank). Address bits 17..13 select the window. A write stores data bits 2..0. A read returns the stored value in bits 2..0, with bits 15..3 zero.
- R2: After reset every level register reads 0, nothing is pending and `irqLevel` is 0.
- R3: An event on a source whose level is non-zero makes that source pending. From the next clock edge `irqLevel` shows that level, if no pending source has a higher level.
- R4: An event on a source whose level is 0 is discarded. Raising that level later does not produce an interrupt.
- R5: `irqLevel` is the highest level among the pending sources, and 0 when none is pending. Two pending sources on the same level keep that level shown until both are acknowledged.
- R6: A read of a source's acknowledge window clears that source and returns 0. The acknowledge windows are 0x16000 (doorbell), 0x18000 (external), 0x1A000 (position), 0x1C000 (serial) and 0x1E000 (vertical blank).
- R7: A write to a source's acknowledge window clears that source, whatever the data.
- R8: A write to window 0x22000 with data bit 1 set clears the vertical-blank request. With bit 1 clear it has no effect.
- R9: When an event and an acknowledge of the same source fall in the same cycle, the source stays pending.
- R10: Rewriting the level of a pending source moves `irqLevel` to the new level from the next edge.
- R11: The vertical-blank event fires once when `scanLine` becomes equal to VBLANK_LINE (480). Holding the counter at that line does not fire it again.
- R12: A read or write of the watchdog window 0x26000 leaves all interrupt state unchanged, and the read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 18 | Byte offset inside the block |
| busWdata | input | 16 | Write data; only the low byte is used |
| busRdata | output | 16 | Read data, combinational from the current address |
| evTrig | input | 4 | Event pulses: bit 0 doorbell, 1 external, 2 position, 3 serial |
| scanLine | input | 10 | Current scan line, for the vertical-blank event |
| irqLevel | output | 3 | Encoded interrupt level to the host, 0 = none |

## Verification
The event and the acknowledge of one source can land on the same clock edge. The bench provokes this by driving an event pulse and an acknowledge write in the same cycle, and it passes only if the level is still shown afterwards and a later plain acknowledge clears it. A second overlap puts a level rewrite on an already pending source: the bench expects `irqLevel` to follow the new value at once, with the request still pending. A third puts an auxiliary write with and without bit 1 on a pending vertical-blank request.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int NUM_SRC = 5;
  localparam int LVL_W   = 3;

  // Source order; level and acknowledge windows follow it consecutively
  localparam int SRC_CPU = 0;
  localparam int SRC_EXT = 1;
  localparam int SRC_POS = 2;
  localparam int SRC_SER = 3;
  localparam int SRC_VB  = 4;

  // Window indices (byte offset >> 13)
  localparam int LVL_WIN_BASE = 3;   // 0x06000
  localparam int ACK_WIN_BASE = 11;  // 0x16000
  localparam int AUX_WIN      = 17;  // 0x22000
  localparam int WDOG_WIN     = 19;  // 0x26000
  localparam int AUX_CLR_BIT  = 1;

  typedef struct packed {
    logic [NUM_SRC-1:0] lvlWr;
    logic [NUM_SRC-1:0] lvlRd;
    logic [NUM_SRC-1:0] ackStb;
    logic               auxWr;
    logic               vbTrig;
  } strobe_t;
endpackage

// File: rtl/prio_irq_decode.sv
module prio_irq_decode
  import prio_irq_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int WIN_SHIFT   = 13,
  parameter int LINE_W      = 10,
  parameter int VBLANK_LINE = 480
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [LINE_W-1:0] scanLine,
  output strobe_t           stb
);
  localparam int WIN_W = ADDR_W - WIN_SHIFT;

  logic [WIN_W-1:0] win;
  logic             unusedLowAddr;
  logic             atLine;
  logic             atLineQ;

  assign win           = busAddr[ADDR_W-1:WIN_SHIFT];
  assign unusedLowAddr = ^busAddr[WIN_SHIFT-1:0];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_win
    assign stb.lvlWr[i]  = busSel &&  busWr && (win == WIN_W'(LVL_WIN_BASE + i));
    assign stb.lvlRd[i]  = busSel && !busWr && (win == WIN_W'(LVL_WIN_BASE + i));
    assign stb.ackStb[i] = busSel && (win == WIN_W'(ACK_WIN_BASE + i));
  end
  // Watchdog window decodes to no strobe at all
  assign stb.auxWr = busSel && busWr && (win == WIN_W'(AUX_WIN));

  assign atLine = (scanLine == LINE_W'(VBLANK_LINE));

  always_ff @(posedge clk) begin
    if (!rstN) atLineQ <= 1'b0;
    else       atLineQ <= atLine;
  end

  assign stb.vbTrig = atLine && !atLineQ;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.lvlWr, stb.lvlRd, stb.ackStb, stb.auxWr})) else $error("strobe overlap"); // R12
  AST_VB_AT_LINE: assert property (@(posedge clk) disable iff (!rstN)
    stb.vbTrig |-> (scanLine == LINE_W'(VBLANK_LINE))) else $error("vblank off line"); // R11
  AST_VB_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    stb.vbTrig |=> !stb.vbTrig) else $error("vblank retrigger"); // R11
endmodule

// File: rtl/prio_irq_core.sv
module prio_irq_core
  import prio_irq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [NUM_SRC-2:0] evTrig,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic [LVL_W-1:0]   irqLevel
);
  logic [LVL_W-1:0]   lvl [NUM_SRC];
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] trig;
  logic [NUM_SRC-1:0] clr;
  logic [LVL_W-1:0]   lvlMax;
  logic [LVL_W-1:0]   rdLvl;
  logic               unusedWdata;

  assign unusedWdata = ^busWdata[DATA_W-1:LVL_W];
  assign trig        = {stb.vbTrig, evTrig};

  always_comb begin
    clr = stb.ackStb;
    clr[SRC_VB] = stb.ackStb[SRC_VB] | (stb.auxWr & busWdata[AUX_CLR_BIT]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend <= '0;
      for (int i = 0; i < NUM_SRC; i++) lvl[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (stb.lvlWr[i]) lvl[i] <= busWdata[LVL_W-1:0];
        if (trig[i] && (lvl[i] != '0)) pend[i] <= 1'b1;
        else if (clr[i])               pend[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    lvlMax = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (pend[i] && (lvl[i] > lvlMax)) lvlMax = lvl[i];
  end
  assign irqLevel = lvlMax;

  always_comb begin
    rdLvl = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (stb.lvlRd[i]) rdLvl = rdLvl | lvl[i];
  end
  assign busRdata = DATA_W'(rdLvl);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    AST_TRIG_LATCH: assert property (@(posedge clk) disable iff (!rstN)
      (trig[i] && (lvl[i] != '0)) |=> pend[i]) else $error("trigger lost"); // R3
    AST_ZERO_LVL_DROP: assert property (@(posedge clk) disable iff (!rstN)
      (trig[i] && (lvl[i] == '0) && !pend[i]) |=> !pend[i]) else $error("level 0 latched"); // R4
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      (clr[i] && !trig[i]) |=> !pend[i]) else $error("ack ignored"); // R6
    AST_TRIG_WINS: assert property (@(posedge clk) disable iff (!rstN)
      (clr[i] && trig[i] && (lvl[i] != '0)) |=> pend[i]) else $error("ack beat trigger"); // R9
    AST_OUT_COVERS: assert property (@(posedge clk) disable iff (!rstN)
      pend[i] |-> (irqLevel >= lvl[i])) else $error("output below pending"); // R5
  end
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (pend == '0) |-> (irqLevel == '0)) else $error("spurious level"); // R5
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int WIN_SHIFT   = 13,
  parameter int DATA_W      = 16,
  parameter int LINE_W      = 10,
  parameter int VBLANK_LINE = 480
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-2:0] evTrig,
  input  logic [LINE_W-1:0]  scanLine,
  output logic [LVL_W-1:0]   irqLevel
);
  strobe_t stb;

  prio_irq_decode #(
    .ADDR_W(ADDR_W), .WIN_SHIFT(WIN_SHIFT), .LINE_W(LINE_W), .VBLANK_LINE(VBLANK_LINE)
  ) u_decode (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .scanLine(scanLine), .stb(stb)
  );

  prio_irq_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rstN(rstN), .stb(stb), .evTrig(evTrig),
    .busWdata(busWdata), .busRdata(busRdata), .irqLevel(irqLevel)
  );
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam logic [17:0] LVL_CPU = 18'h06000, LVL_EXT = 18'h08000, LVL_POS = 18'h0A000,
                          LVL_SER = 18'h0C000, LVL_VB  = 18'h0E000;
  localparam logic [17:0] ACK_CPU = 18'h16000, ACK_EXT = 18'h18000, ACK_POS = 18'h1A000,
                          ACK_SER = 18'h1C000, ACK_VB  = 18'h1E000;
  localparam logic [17:0] AUX = 18'h22000, WDOG = 18'h26000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [17:0] busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [3:0]  evTrig = '0;
  logic [9:0]  scanLine = '0;
  logic [2:0]  irqLevel;

  int checks = 0, errors = 0, cycles = 0;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .evTrig(evTrig),
    .scanLine(scanLine), .irqLevel(irqLevel)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [17:0] a, input logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [17:0] a, output int d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic pulse(input int src);
    @(negedge clk);
    evTrig[src] = 1'b1;
    @(negedge clk);
    evTrig = '0;
  endtask

  task automatic t_reset();
    int d;
    chk("R2 irq after reset", irqLevel, 0);
    busRead(LVL_CPU, d); chk("R2 cpu level", d, 0);
    busRead(LVL_VB, d);  chk("R2 vblank level", d, 0);
  endtask

  task automatic t_levelRw();
    int d;
    busWrite(LVL_EXT, 16'hFFF5); busRead(LVL_EXT, d); chk("R1 ext level masked", d, 5);
    busWrite(LVL_POS, 16'h0003); busRead(LVL_POS, d); chk("R1 pos level", d, 3);
    busWrite(LVL_SER, 16'h0106); busRead(LVL_SER, d); chk("R1 ser level", d, 6);
    busWrite(LVL_CPU, 16'h0002); busRead(LVL_CPU, d); chk("R1 cpu level", d, 2);
    busRead(LVL_EXT, d); chk("R1 ext retained", d, 5);
  endtask

  task automatic t_priority();
    int d;
    busWrite(LVL_EXT, 3); busWrite(LVL_POS, 6);
    pulse(1); chk("R3 ext raises 3", irqLevel, 3);
    pulse(2); chk("R5 pos wins with 6", irqLevel, 6);
    busWrite(ACK_POS, 16'h0000); chk("R7 write ack pos", irqLevel, 3);
    busRead(ACK_EXT, d); chk("R6 ack read data", d, 0);
    chk("R6 read ack ext", irqLevel, 0);
  endtask

  task automatic t_sameLevel();
    busWrite(LVL_CPU, 2); busWrite(LVL_SER, 2);
    pulse(0); pulse(3); chk("R5 shared level", irqLevel, 2);
    busWrite(ACK_CPU, 16'hFFFF); chk("R5 one of two acked", irqLevel, 2);
    busWrite(ACK_SER, 16'h0000); chk("R5 both acked", irqLevel, 0);
  endtask

  task automatic t_zeroLevel();
    busWrite(LVL_SER, 0);
    pulse(3); chk("R4 level 0 event", irqLevel, 0);
    busWrite(LVL_SER, 4); chk("R4 raised later", irqLevel, 0);
  endtask

  task automatic t_vblank();
    busWrite(LVL_VB, 7);
    @(negedge clk); scanLine = 10'd479;
    @(negedge clk); chk("R11 before line", irqLevel, 0);
    scanLine = 10'd480;
    @(negedge clk); chk("R11 at line", irqLevel, 7);
    busWrite(AUX, 16'h0001); chk("R8 aux without bit1", irqLevel, 7);
    busWrite(AUX, 16'h0002); chk("R8 aux bit1 clears", irqLevel, 0);
    repeat (4) @(negedge clk);
    chk("R11 held line no refire", irqLevel, 0);
    scanLine = 10'd0;
    @(negedge clk); scanLine = 10'd480;
    @(negedge clk); chk("R11 next frame", irqLevel, 7);
    busWrite(ACK_VB, 0); chk("R7 ack vblank", irqLevel, 0);
    busWrite(LVL_VB, 0);
  endtask

  task automatic t_collide();
    busWrite(LVL_EXT, 3);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = ACK_EXT; busWdata = 0; evTrig[1] = 1'b1;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; evTrig = '0;
    chk("R9 trigger beats ack", irqLevel, 3);
    busWrite(ACK_EXT, 0); chk("R9 later ack clears", irqLevel, 0);
  endtask

  task automatic t_levelMove();
    pulse(1); chk("R3 ext pending", irqLevel, 3);
    busWrite(LVL_EXT, 5); chk("R10 level up", irqLevel, 5);
    busWrite(LVL_EXT, 1); chk("R10 level down", irqLevel, 1);
    busWrite(LVL_EXT, 3);
  endtask

  task automatic t_watchdog();
    int d;
    busWrite(WDOG, 16'hFFFF); chk("R12 kick write", irqLevel, 3);
    busRead(WDOG, d); chk("R12 kick read data", d, 0);
    chk("R12 kick read state", irqLevel, 3);
    busRead(LVL_EXT, d); chk("R12 level kept", d, 3);
    busWrite(ACK_EXT, 0); chk("R7 final ack", irqLevel, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_levelRw();
    t_priority();
    t_sameLevel();
    t_zeroLevel();
    t_vblank();
    t_collide();
    t_levelMove();
    t_watchdog();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule